// File: doc/BRIEF.md
# Byte Stack Push/Pull Engine

This block moves single bytes between two internal accumulators (A and B) and a stack held in an external byte-wide RAM. It keeps a 16-bit stack pointer. The pointer always names the next free byte, and the stack grows toward lower addresses. A push writes the chosen accumulator at the pointer and then steps the pointer down. A pull steps the pointer up and then reads that byte into the chosen accumulator, which frees the location again.

The RAM is expected to have a synchronous read with one cycle of latency. The block always drives the stack pointer on the RAM address. A caller raises `push_i` or `pull_i` for one cycle while `busy_o` is low, with `sel_b_i` choosing the accumulator. The caller then waits for `done_o`. A synchronous load input sets the pointer to any 16-bit value. The operations affect no condition flags, and the block has none.

Top module: `byte_stack_engine`

## Requirements
- R1: While reset is active, and after it is released, the pointer holds parameter `SP_RST` (default 0x00FF), both accumulators are 0x00, and `busy_o`, `done_o` and `mem_we_o` are low.
- R2: When `sp_load_i` is high at a clock edge, the pointer equals `sp_load_val_i` after that edge and the engine is idle. The load takes priority over a push or pull request raised in the same cycle, and that request is dropped.
- R3: A push is accepted at an edge where `push_i` is high and `busy_o` is low. In the cycle that follows, `mem_we_o`, `busy_o` and `done_o` are high and `mem_addr_o` equals the pointer from before the request. `mem_wdata_o` carries accumulator A when `sel_b_i` was 0, or accumulator B when it was 1.
- R4: After the push write cycle, the pointer is one lower than before and `busy_o` is low.
- R5: A pull is accepted at an edge where `pull_i` is high, `push_i` is low and `busy_o` is low. In the next cycle the pointer and `mem_addr_o` are one higher than before. In the cycle after that, `done_o` is high. After that cycle the selected accumulator holds the RAM byte at the incremented address and `busy_o` is low.
- R6: A pull changes only the accumulator it selects (`sel_b_i` 0 = A, 1 = B). Pushes leave both accumulators unchanged.
- R7: The pointer wraps modulo 2^16. A push at 0x0000 writes address 0x0000 and leaves 0xFFFF. A pull at 0xFFFF reads address 0x0000.
- R8: Push and pull requests raised while `busy_o` is high are ignored. They cause no extra write, no pointer change and no accumulator change.
- R9: When push and pull are requested together while idle, only the push is performed.
- R10: `mem_we_o` is high only in the single write cycle of an accepted push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sp_load_i | input | 1 | Synchronous pointer load |
| sp_load_val_i | input | 16 | Value for the pointer load |
| push_i | input | 1 | Push request |
| pull_i | input | 1 | Pull request |
| sel_b_i | input | 1 | Accumulator select: 0 = A, 1 = B |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final cycle of an operation |
| mem_addr_o | output | 16 | RAM address (the stack pointer) |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the address |
| sp_o | output | 16 | Current stack pointer |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |

## Verification
A pointer that goes wrong shows up on `mem_addr_o` and `sp_o` within the cycle after the faulty edge. Every later push then lands at a wrong address, which the write scoreboard catches on the next write. A sequencer stuck in the wrong state shows up as `busy_o` or `done_o` arriving a cycle early or late, or as a missing or extra `mem_we_o` pulse. A wrong select latch puts the wrong byte on `mem_wdata_o` or loads the wrong accumulator, and the check one cycle after `done_o` exposes it.

// File: rtl/bstk_pkg.sv
package bstk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PUSH     = 2'd1,
    ST_PULL_RD  = 2'd2,
    ST_PULL_CAP = 2'd3
  } bstk_state_e;

  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_LOAD = 2'd1,
    SP_INC  = 2'd2,
    SP_DEC  = 2'd3
  } sp_op_e;
endpackage

// File: rtl/bstk_ptr.sv
module bstk_ptr
  import bstk_pkg::*;
#(
  parameter int          AW     = 16,
  parameter logic [AW-1:0] SP_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_op_e        op_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] sp_q, sp_d;
  logic          sp_en;

  always_comb begin
    sp_en = 1'b1;
    sp_d  = sp_q;
    unique case (op_i)
      SP_LOAD: sp_d = load_val_i;
      SP_INC:  sp_d = sp_q + ONE;
      SP_DEC:  sp_d = sp_q - ONE;
      default: sp_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RST;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/bstk_acc.sv
module bstk_acc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a_i,
  input  logic          we_b_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] acc_a_o,
  output logic [DW-1:0] acc_b_o
);
  logic [DW-1:0] a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      a_q <= '0;
    else if (we_a_i) a_q <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      b_q <= '0;
    else if (we_b_i) b_q <= din_i;
  end

  assign acc_a_o = a_q;
  assign acc_b_o = b_q;
endmodule

// File: rtl/bstk_seq.sv
module bstk_seq
  import bstk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic        push_i,
  input  logic        pull_i,
  input  logic        sel_b_i,
  output bstk_state_e state_o,
  output logic        sel_b_q_o,
  output sp_op_e      sp_op_o,
  output logic        acc_we_a_o,
  output logic        acc_we_b_o
);
  bstk_state_e state_q, state_d;
  logic        sel_q, sel_d, sel_en;

  always_comb begin
    state_d    = state_q;
    sp_op_o    = SP_HOLD;
    sel_en     = 1'b0;
    sel_d      = sel_b_i;
    acc_we_a_o = 1'b0;
    acc_we_b_o = 1'b0;
    if (load_i) begin
      sp_op_o = SP_LOAD;
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (push_i) begin
            state_d = ST_PUSH;
            sel_en  = 1'b1;
          end else if (pull_i) begin
            state_d = ST_PULL_RD;
            sel_en  = 1'b1;
            sp_op_o = SP_INC;
          end
        end
        ST_PUSH: begin
          sp_op_o = SP_DEC;
          state_d = ST_IDLE;
        end
        ST_PULL_RD: state_d = ST_PULL_CAP;
        ST_PULL_CAP: begin
          acc_we_a_o = ~sel_q;
          acc_we_b_o = sel_q;
          state_d    = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign state_o   = state_q;
  assign sel_b_q_o = sel_q;
endmodule

// File: rtl/byte_stack_engine.sv
module byte_stack_engine
  import bstk_pkg::*;
#(
  parameter int              AW     = 16,
  parameter int              DW     = 8,
  parameter logic [AW-1:0]   SP_RST = AW'(16'h00FF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_load_i,
  input  logic [AW-1:0] sp_load_val_i,
  input  logic          push_i,
  input  logic          pull_i,
  input  logic          sel_b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] sp_o,
  output logic [DW-1:0] acc_a_o,
  output logic [DW-1:0] acc_b_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[SYNC_STAGES-1];

  bstk_state_e state;
  sp_op_e      sp_op;
  logic        sel_b_q, we_a, we_b;
  logic [AW-1:0] sp;

  bstk_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .load_i     (sp_load_i),
    .push_i     (push_i),
    .pull_i     (pull_i),
    .sel_b_i    (sel_b_i),
    .state_o    (state),
    .sel_b_q_o  (sel_b_q),
    .sp_op_o    (sp_op),
    .acc_we_a_o (we_a),
    .acc_we_b_o (we_b)
  );

  bstk_ptr #(.AW(AW), .SP_RST(SP_RST)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .op_i       (sp_op),
    .load_val_i (sp_load_val_i),
    .sp_o       (sp)
  );

  bstk_acc #(.DW(DW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .we_a_i  (we_a),
    .we_b_i  (we_b),
    .din_i   (mem_rdata_i),
    .acc_a_o (acc_a_o),
    .acc_b_o (acc_b_o)
  );

  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_PUSH) || (state == ST_PULL_CAP);
  assign mem_we_o    = (state == ST_PUSH);
  assign mem_addr_o  = sp;
  assign mem_wdata_o = sel_b_q ? acc_b_o : acc_a_o;
  assign sp_o        = sp;
endmodule

// File: rtl/bstk_chk.sv
module bstk_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          sp_load_i,
  input logic [AW-1:0] sp_load_val_i,
  input logic          push_i,
  input logic          pull_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [AW-1:0] sp_o,
  input logic [DW-1:0] acc_a_o,
  input logic [DW-1:0] acc_b_o
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    sp_load_i |=> (sp_o == $past(sp_load_val_i)) && !busy_o);

  assert_push_write_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (push_i && !busy_o && !sp_load_i) |=>
      (mem_we_o && done_o && mem_addr_o == $past(sp_o)));

  assert_push_data_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_we_o |-> (mem_wdata_o == acc_a_o || mem_wdata_o == acc_b_o));

  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_we_o && !sp_load_i) |=> (sp_o == $past(sp_o) - AW'(1)) && !busy_o);

  assert_pull_inc_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pull_i && !push_i && !busy_o && !sp_load_i) |=>
      (sp_o == $past(sp_o) + AW'(1)) && busy_o && !mem_we_o);

  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(done_o && !mem_we_o) |=> ($stable(acc_a_o) && $stable(acc_b_o)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy_o |-> (!mem_we_o && !done_o));

  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_we_o |=> !mem_we_o);
endmodule

bind byte_stack_engine bstk_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .sp_load_i     (sp_load_i),
  .sp_load_val_i (sp_load_val_i),
  .push_i        (push_i),
  .pull_i        (pull_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .mem_addr_o    (mem_addr_o),
  .mem_we_o      (mem_we_o),
  .mem_wdata_o   (mem_wdata_o),
  .sp_o          (sp_o),
  .acc_a_o       (acc_a_o),
  .acc_b_o       (acc_b_o)
);

// File: tb/byte_stack_engine_bench.sv
module byte_stack_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sp_load_i;
  logic [15:0] sp_load_val_i;
  logic        push_i, pull_i, sel_b_i;
  logic        busy_o, done_o, mem_we_o;
  logic [15:0] mem_addr_o, sp_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, acc_a_o, acc_b_o;

  int errors = 0;
  int checks = 0;

  logic [7:0]  ram [int];
  logic [15:0] exp_sp;
  logic [7:0]  exp_a, exp_b;
  logic [23:0] wr_q [$];   // {addr, data}

  always #4 clk = ~clk;

  byte_stack_engine u_byte_stack_engine (
    .clk(clk), .rst_n(rst_n), .sp_load_i(sp_load_i), .sp_load_val_i(sp_load_val_i),
    .push_i(push_i), .pull_i(pull_i), .sel_b_i(sel_b_i), .busy_o(busy_o),
    .done_o(done_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .sp_o(sp_o),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o)
  );

  // RAM model: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (mem_we_o) ram[int'(mem_addr_o)] = mem_wdata_o;
    mem_rdata_i <= ram.exists(int'(mem_addr_o)) ? ram[int'(mem_addr_o)] : 8'h00;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares every write against the scoreboard (R3, R7, R8, R10)
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      checks++;
      if (wr_q.size() == 0) begin
        errors++;
        $display("FAIL R10 actual=%0h expected=none", {mem_addr_o, mem_wdata_o});
      end else begin
        logic [23:0] e;
        e = wr_q.pop_front();
        if ({mem_addr_o, mem_wdata_o} !== e) begin
          errors++;
          $display("FAIL R3 actual=%0h expected=%0h", {mem_addr_o, mem_wdata_o}, e);
        end
      end
    end
  end

  task automatic do_load(input logic [15:0] v);
    @(negedge clk);
    sp_load_i = 1'b1; sp_load_val_i = v;
    @(negedge clk);
    sp_load_i = 1'b0;
    exp_sp = v;
    chk("R2 load", sp_o, v);
  endtask

  task automatic do_push(input logic sel, input logic noise);
    @(negedge clk);
    push_i = 1'b1; sel_b_i = sel;
    wr_q.push_back({exp_sp, sel ? exp_b : exp_a});
    @(negedge clk);
    push_i = noise; pull_i = noise; sel_b_i = ~sel;
    chk("R3 busy", busy_o, 1'b1);
    chk("R3 done", done_o, 1'b1);
    chk("R3 addr", mem_addr_o, exp_sp);
    @(negedge clk);
    push_i = 1'b0; pull_i = 1'b0;
    exp_sp = exp_sp - 16'd1;
    chk("R4 sp", sp_o, exp_sp);
    chk("R4 busy", busy_o, 1'b0);
    chk("R6 acc", {acc_a_o, acc_b_o}, {exp_a, exp_b});
  endtask

  task automatic do_pull(input logic sel, input logic noise);
    logic [7:0] v;
    @(negedge clk);
    pull_i = 1'b1; sel_b_i = sel;
    @(negedge clk);
    pull_i = noise; push_i = noise; sel_b_i = ~sel;
    exp_sp = exp_sp + 16'd1;
    chk("R5 sp", sp_o, exp_sp);
    chk("R5 addr", mem_addr_o, exp_sp);
    chk("R5 busy", busy_o, 1'b1);
    @(negedge clk);
    chk("R5 done", done_o, 1'b1);
    chk("R8 nowrite", mem_we_o, 1'b0);
    @(negedge clk);
    push_i = 1'b0; pull_i = 1'b0;
    v = ram.exists(int'(exp_sp)) ? ram[int'(exp_sp)] : 8'h00;
    if (sel) exp_b = v; else exp_a = v;
    chk("R5 busy end", busy_o, 1'b0);
    chk("R6 acc", {acc_a_o, acc_b_o}, {exp_a, exp_b});
    chk("R8 sp", sp_o, exp_sp);
  endtask

  initial begin
    rst_n = 1'b0; sp_load_i = 1'b0; sp_load_val_i = '0;
    push_i = 1'b0; pull_i = 1'b0; sel_b_i = 1'b0;
    exp_a = 8'h00; exp_b = 8'h00; exp_sp = 16'h00FF;
    repeat (3) @(negedge clk);
    chk("R1 sp in reset", sp_o, 16'h00FF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sp", sp_o, 16'h00FF);
    chk("R1 accs", {acc_a_o, acc_b_o}, 16'h0000);
    chk("R1 flags", {busy_o, done_o, mem_we_o}, 3'b000);

    ram[32'h0101] = 8'h5A;
    ram[32'h0102] = 8'hC3;
    do_load(16'h0100);
    do_pull(1'b0, 1'b0);            // A <= 5A
    do_pull(1'b1, 1'b0);            // B <= C3
    do_push(1'b1, 1'b0);            // C3 @0102
    do_push(1'b0, 1'b0);            // 5A @0101
    do_pull(1'b1, 1'b0);            // B <= 5A

    // R8: requests during busy ignored
    do_push(1'b0, 1'b1);
    do_pull(1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R8 idle", {busy_o, sp_o}, {1'b0, exp_sp});

    // R7: wrap both ways
    do_load(16'h0000);
    do_push(1'b1, 1'b0);
    chk("R7 wrap down", sp_o, 16'hFFFF);
    do_pull(1'b0, 1'b0);
    chk("R7 wrap up", {sp_o, acc_a_o}, {16'h0000, exp_b});

    // R9: push beats pull
    @(negedge clk);
    push_i = 1'b1; pull_i = 1'b1; sel_b_i = 1'b0;
    wr_q.push_back({exp_sp, exp_a});
    @(negedge clk);
    push_i = 1'b0; pull_i = 1'b0;
    chk("R9 write", mem_we_o, 1'b1);
    @(negedge clk);
    exp_sp = exp_sp - 16'd1;
    chk("R9 sp", sp_o, exp_sp);
    chk("R9 acc", {acc_a_o, acc_b_o}, {exp_a, exp_b});

    // R2: load beats push
    @(negedge clk);
    sp_load_i = 1'b1; sp_load_val_i = 16'h4000; push_i = 1'b1;
    @(negedge clk);
    sp_load_i = 1'b0; push_i = 1'b0; exp_sp = 16'h4000;
    chk("R2 priority", {busy_o, mem_we_o, sp_o}, {2'b00, 16'h4000});
    @(negedge clk);
    chk("R2 dropped", {busy_o, sp_o}, {1'b0, 16'h4000});

    repeat (2) @(negedge clk);
    chk("R10 queue empty", wr_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule